// File: doc/BRIEF.md
# Shared Interrupt Affinity Router

This block holds the routing setting of every shared interrupt in an interrupt controller. Each shared interrupt (interrupt IDs 32 and up, addressed here by their offset from 32) has one 64-bit routing register. Software writes an affinity value into it. The block keeps a compressed 32-bit copy so that later reads return what was written. On the same write it compares the affinity with a table of the affinities of the CPUs present in the system, which gives a target CPU index.

For each CPU the block keeps a bitmap of the shared interrupts aimed at it. A routing write moves the interrupt's bit from the old target's bitmap to the new one in a single clock edge. An affinity that matches no present CPU gives a reserved "not allocated" index and no bitmap bit. Such an interrupt can still be made pending elsewhere, but the delivery logic downstream never forwards it.

The CPU affinity table enters as a flat input vector and is expected to stay constant while the block runs. Delivery and prioritisation are not part of this block.

Top module: `spi_affinity_router`

## Requirements
- R1: After a synchronous reset, every shared interrupt has target index 0 with its valid flag set. CPU 0's bitmap is all ones and every other CPU's bitmap is zero. A read of any routing register returns CPU 0's affinity.
- R2: The result of a read appears on `rdata_o`, with `rvalid_o` high, on the clock edge after the one that samples `rd_en_i`. The value has bits [7:0], [15:8] and [23:16] equal to affinity levels 0, 1 and 2 as last written to that interrupt. A read in the same cycle as a write to the same interrupt returns the value from before that write.
- R3: Bits [63:24] of every routing register read as zero. Bits [63:24] of the write data have no effect on the stored value or on the matching. Level 3 (the top byte of the compressed word) is always taken as zero.
- R4: A write whose compressed affinity is equal in all four bytes to a CPU table entry does three things, all visible after the next clock edge. It sets that interrupt's target index to the CPU number, with the valid flag high. It sets the interrupt's bit in that CPU's bitmap. It clears the bit in the bitmap of the previous target.
- R5: A write whose affinity matches no table entry does three things. It sets the target index to 8'hFF with the valid flag low. It clears the interrupt's bit from the previous target's bitmap. It sets no bitmap bit.
- R6: At every cycle, each interrupt's bit is set in at most one CPU bitmap. When the valid flag is high, the bit is set in the bitmap of the CPU named by the target index.
- R7: When several table entries hold the same affinity, the lowest-numbered CPU is chosen.
- R8: A write changes only the target, the bitmap bits and the stored value of the interrupt it addresses. An interrupt that is not allocated becomes allocated again when it is rewritten with a matching affinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_aff_i | input | NUM_CPU*32 | Compressed affinity of each CPU; CPU c in bits [32c+31:32c] |
| wr_en_i | input | 1 | Write strobe for the routing register selected by `spi_i` |
| rd_en_i | input | 1 | Read strobe for the routing register selected by `spi_i` |
| spi_i | input | clog2(NUM_SPI) | Shared interrupt number minus 32 |
| wdata_i | input | 64 | Routing register write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 64 | Routing register read data |
| tgt_idx_o | output | NUM_SPI*8 | Target CPU index per interrupt; interrupt s in bits [8s+7:8s]; 8'hFF = not allocated |
| tgt_vld_o | output | NUM_SPI | Target valid per interrupt |
| cpu_map_o | output | NUM_CPU*NUM_SPI | Per-CPU target bitmaps; bit c*NUM_SPI+s means interrupt s targets CPU c |

## Verification
Some properties are checked on every cycle. These are the exclusivity of an interrupt's bitmap bit across CPUs, its agreement with the target index, the reserved code used for unallocated targets, the state just after reset, and the one-cycle read handshake. Other behaviour can only be shown by the bench's scenarios. This covers readback of the written affinity, the dropping of the upper bits, lowest-index selection between duplicate CPU affinities, the move from allocated to unallocated and back, and writes leaving the other interrupts' state alone. A scoreboard compares every read result against a model of the register contents.

// File: rtl/aff_route_pkg.sv
package aff_route_pkg;

  localparam int AFF_W = 32;
  localparam int REG_W = 64;

  // Register value -> stored word: levels 0..2 kept, level 3 forced to zero
  // because the upper register half is ignored.
  function automatic logic [AFF_W-1:0] pack_aff(input logic [REG_W-1:0] r);
    return {8'h00, r[23:16], r[15:8], r[7:0]};
  endfunction

  // Stored word -> register value; everything above level 2 reads zero.
  function automatic logic [REG_W-1:0] unpack_aff(input logic [AFF_W-1:0] c);
    return {40'h0, c[23:0]};
  endfunction

endpackage

// File: rtl/aff_matcher.sv
module aff_matcher #(
  parameter int NUM_CPU = 4,
  parameter int IDX_W   = 8
) (
  input  logic [NUM_CPU*32-1:0] cpu_aff_i,
  input  logic [31:0]           key_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      cpu_o
);
  localparam logic [IDX_W-1:0] NO_CPU = '1;

  logic [NUM_CPU-1:0] eq;

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cmp
      assign eq[c] = (cpu_aff_i[c*32 +: 32] == key_i);
    end
  endgenerate

  // lowest-numbered matching CPU wins
  always_comb begin
    hit_o = 1'b0;
    cpu_o = NO_CPU;
    for (int c = NUM_CPU - 1; c >= 0; c--) begin
      if (eq[c]) begin
        hit_o = 1'b1;
        cpu_o = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/aff_store.sv
module aff_store #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, read-first; no reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/route_state.sv
module route_state #(
  parameter int NUM_SPI = 32,
  parameter int NUM_CPU = 4,
  parameter int IDX_W   = 8,
  parameter int SW      = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_i,
  input  logic [SW-1:0]              spi_i,
  input  logic                       hit_i,
  input  logic [IDX_W-1:0]           cpu_i,
  output logic [NUM_SPI*IDX_W-1:0]   tgt_idx_o,
  output logic [NUM_SPI-1:0]         tgt_vld_o,
  output logic [NUM_CPU*NUM_SPI-1:0] cpu_map_o
);
  localparam int CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam logic [IDX_W-1:0] NO_CPU = '1;

  logic [IDX_W-1:0]   idx_q [NUM_SPI];
  logic [NUM_SPI-1:0] vld_q;
  logic [NUM_SPI-1:0] map_q [NUM_CPU];

  logic [CW-1:0] old_c, new_c;
  assign old_c = idx_q[spi_i][CW-1:0];
  assign new_c = cpu_i[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SPI; s++) idx_q[s] <= '0;
      vld_q <= '1;
      for (int c = 0; c < NUM_CPU; c++) map_q[c] <= (c == 0) ? '1 : '0;
    end else if (wr_i) begin
      // old bit cleared first; a set to the same CPU overrides it
      if (vld_q[spi_i]) map_q[old_c][spi_i] <= 1'b0;
      if (hit_i)        map_q[new_c][spi_i] <= 1'b1;
      idx_q[spi_i] <= hit_i ? cpu_i : NO_CPU;
      vld_q[spi_i] <= hit_i;
    end
  end

  assign tgt_vld_o = vld_q;

  generate
    for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi
      logic [NUM_CPU-1:0] col;
      assign tgt_idx_o[s*IDX_W +: IDX_W] = idx_q[s];
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_col
        assign col[c] = cpu_map_o[c*NUM_SPI + s];
      end

      // R6
      one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col));

      // R6
      map_agree_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_vld_o[s] |-> (col == (NUM_CPU'(1) << tgt_idx_o[s*IDX_W +: CW])));

      // R5
      unalloc_code_chk: assert property (@(posedge clk) disable iff (rst)
        !tgt_vld_o[s] |-> (tgt_idx_o[s*IDX_W +: IDX_W] == NO_CPU && col == '0));
    end
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_map
      assign cpu_map_o[c*NUM_SPI +: NUM_SPI] = map_q[c];
    end
  endgenerate
endmodule

// File: rtl/spi_affinity_router.sv
module spi_affinity_router #(
  parameter int NUM_SPI = 32,
  parameter int NUM_CPU = 4,
  parameter int IDX_W   = 8,
  localparam int SW     = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CPU*32-1:0]      cpu_aff_i,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [SW-1:0]              spi_i,
  input  logic [63:0]                wdata_i,
  output logic                       rvalid_o,
  output logic [63:0]                rdata_o,
  output logic [NUM_SPI*IDX_W-1:0]   tgt_idx_o,
  output logic [NUM_SPI-1:0]         tgt_vld_o,
  output logic [NUM_CPU*NUM_SPI-1:0] cpu_map_o
);
  import aff_route_pkg::*;

  logic             in_range, wr_ok;
  logic [AFF_W-1:0] key, ram_q;
  logic             hit;
  logic [IDX_W-1:0] hit_cpu;
  logic [NUM_SPI-1:0] written_q;
  logic             rvalid_q, rsel_q, rrange_q;

  assign in_range = (32'(spi_i) < NUM_SPI);
  assign wr_ok    = wr_en_i & in_range;
  assign key      = pack_aff(wdata_i);

  aff_matcher #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_match (
    .cpu_aff_i (cpu_aff_i),
    .key_i     (key),
    .hit_o     (hit),
    .cpu_o     (hit_cpu)
  );

  aff_store #(.DEPTH(NUM_SPI), .AW(SW), .DW(AFF_W)) u_store (
    .clk     (clk),
    .we_i    (wr_ok),
    .waddr_i (spi_i),
    .wdata_i (key),
    .re_i    (rd_en_i),
    .raddr_i (spi_i),
    .rdata_o (ram_q)
  );

  route_state #(.NUM_SPI(NUM_SPI), .NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .SW(SW)) u_state (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (wr_ok),
    .spi_i     (spi_i),
    .hit_i     (hit),
    .cpu_i     (hit_cpu),
    .tgt_idx_o (tgt_idx_o),
    .tgt_vld_o (tgt_vld_o),
    .cpu_map_o (cpu_map_o)
  );

  // entries never written read back CPU 0's affinity, so the RAM needs no reset
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      rvalid_q  <= 1'b0;
      rsel_q    <= 1'b0;
      rrange_q  <= 1'b0;
    end else begin
      if (wr_ok) written_q[spi_i] <= 1'b1;
      rvalid_q <= rd_en_i;
      rsel_q   <= in_range & written_q[spi_i];
      rrange_q <= in_range;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = (rvalid_q && rrange_q) ?
                    unpack_aff(rsel_q ? ram_q : cpu_aff_i[AFF_W-1:0]) : '0;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[63:24], ram_q[31:24]};

  // R2
  read_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rvalid_o);

  // R4
  hit_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && hit) |=> tgt_vld_o[$past(spi_i)]);

  // R5
  miss_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !hit) |=> !tgt_vld_o[$past(spi_i)]);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&tgt_vld_o && cpu_map_o[NUM_SPI-1:0] == '1));
endmodule

// File: tb/sim_spi_affinity_router.sv
module sim_spi_affinity_router;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC*32-1:0] cpu_aff;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [SW-1:0] spi = '0;
  logic [63:0] wdata = '0;
  logic rvalid;
  logic [63:0] rdata;
  logic [NS*8-1:0] tgt_idx;
  logic [NS-1:0] tgt_vld;
  logic [NC*NS-1:0] cpu_map;

  always #2.5 clk = ~clk;

  // CPU table: CPU3 duplicates CPU1's affinity
  logic [31:0] tab [NC];
  initial begin
    tab[0] = 32'h0000_0A05; tab[1] = 32'h0000_0001;
    tab[2] = 32'h0001_0203; tab[3] = 32'h0000_0001;
  end
  assign cpu_aff = {tab[3], tab[2], tab[1], tab[0]};

  spi_affinity_router #(.NUM_SPI(NS), .NUM_CPU(NC)) u0 (
    .clk(clk), .rst(rst), .cpu_aff_i(cpu_aff), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .spi_i(spi), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata),
    .tgt_idx_o(tgt_idx), .tgt_vld_o(tgt_vld), .cpu_map_o(cpu_map));

  int checks = 0, fails = 0;
  logic [23:0] m_aff [NS];
  logic [7:0]  m_tgt [NS];
  logic [63:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [7:0] find_cpu(input logic [23:0] a);
    for (int c = 0; c < NC; c++) if (tab[c] == {8'h00, a}) return 8'(c);
    return 8'hFF;
  endfunction

  task automatic do_write(input int s, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; spi = SW'(s); wdata = d;
    m_aff[s] = d[23:0];
    m_tgt[s] = find_cpu(d[23:0]);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input int s, input string tag);
    @(negedge clk);
    rd_en = 1'b1; spi = SW'(s);
    exp_q.push_back({40'h0, m_aff[s]});
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops expected read data when the design presents a result
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      logic [63:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected read data act=%h exp=none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s read act=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic check_state(input string tag);
    int bad = 0;
    checks++;
    for (int s = 0; s < NS; s++) begin
      logic [7:0] ai;
      ai = tgt_idx[s*8 +: 8];
      if (ai !== m_tgt[s] || tgt_vld[s] !== (m_tgt[s] != 8'hFF)) begin
        bad++;
        $display("FAIL %s spi%0d tgt act=%h/%b exp=%h", tag, s, ai, tgt_vld[s], m_tgt[s]);
      end
      for (int c = 0; c < NC; c++) begin
        logic eb;
        eb = (m_tgt[s] == 8'(c));
        if (cpu_map[c*NS + s] !== eb) begin
          bad++;
          $display("FAIL %s map cpu%0d spi%0d act=%b exp=%b", tag, c, s, cpu_map[c*NS + s], eb);
        end
      end
    end
    if (bad != 0) fails++;
  endtask

  bit done = 1'b0;
  initial begin
    #200000ns;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin m_aff[s] = 24'h000A05; m_tgt[s] = 8'h00; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rvalid !== 1'b0) begin fails++; $display("FAIL R1 rvalid act=%b exp=0", rvalid); end
    check_state("R1");
    do_read(0, "R1");
    do_read(31, "R1");

    do_write(3, 64'h0000_0000_0001_0203);
    check_state("R4");
    do_read(3, "R2");

    // upper bits set: ignored, still matches CPU1 (lowest of 1 and 3, R7)
    do_write(3, 64'hDEAD_BEEF_C300_0001);
    check_state("R3");
    do_read(3, "R3");

    do_write(7, 64'h0000_0000_0000_0001);
    check_state("R7");

    do_write(3, 64'h0000_0000_0077_7777);
    check_state("R5");
    do_read(3, "R5");
    do_read(7, "R8");

    do_write(3, 64'h0000_0000_0000_0A05);
    check_state("R8");
    do_read(3, "R8");

    for (int s = 0; s < NS; s++) begin
      case (s % 5)
        0: do_write(s, 64'h0000_0A05);
        1: do_write(s, 64'h0000_0001);
        2: do_write(s, 64'h0001_0203);
        3: do_write(s, 64'h00AB_CDEF);
        default: do_write(s, 64'hFFFF_FFFF_FF01_0203);
      endcase
    end
    check_state("R4");
    for (int s = 0; s < NS; s++) do_read(s, "R2");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 pending reads act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule